// File: doc/BRIEF.md
# Receive FIFO Idle-Character Timeout

This block watches a UART receive FIFO and raises a flag when characters have been sitting in it for too long without reaching the trigger level. Small bursts that never fill the FIFO up to the level that raises the receive-ready flag would otherwise go unnoticed. This block lets software find out about them after a fixed quiet period.

The timer counts only while its window is open. The window is open when the FIFO is not empty and the receive-ready flag is low. Any push into the FIFO or pop from it restarts the count from zero. When the count reaches the timeout, the block sets a sticky status bit and the timer stops. It stays stopped until the next push or pop. Software clears the status bit with a one-cycle write-one-to-clear strobe. The interrupt contribution is that bit gated by an enable.

The timeout is `CYCLES_PER_BIT * CHAR_BITS * AGE_CHARS` clock cycles. By default this is eight 10-bit characters at roughly 115200 baud from a 100 MHz clock, i.e. 69440 cycles. The FIFO, the trigger comparison and baud generation all live outside this block. The FIFO flags are expected to settle one cycle after each push or pop. The reset input is assumed to be synchronised upstream.

Top module: `rx_fifo_ageing`

## Requirements
- R1: After reset, `age_status` and `age_irq` are 0 and the timer is stopped. With the window open and no push or pop, no expiry ever occurs.
- R2: `age_status` rises exactly TIMEOUT clock edges after the last edge that sampled `push` or `pop` high, provided the window was open at every edge in between. TIMEOUT is `CYCLES_PER_BIT*CHAR_BITS*AGE_CHARS`. The window is open when `fifo_empty`=0 and `rx_ready`=0.
- R3: A push (`push`=1) at any point in a running count restarts the count from zero.
- R4: A pop (`pop`=1) at any point in a running count restarts the count from zero.
- R5: An edge that samples `fifo_empty`=1 with no push or pop stops the timer without expiry. Reopening the window later does not resume the count.
- R6: An edge that samples `rx_ready`=1 with no push or pop stops the timer without expiry. Reopening the window later does not resume the count.
- R7: `age_status` stays 1 until an edge samples `age_clr`=1. If an expiry and a clear fall on the same edge, the bit ends up 1.
- R8: `age_irq` equals `age_status` when `age_irq_en`=1 and is 0 when `age_irq_en`=0.
- R9: After an expiry the timer stays stopped. Clearing the status then leaves it 0 for as long as no push or pop arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fifo_empty | input | 1 | Receive FIFO holds no characters |
| rx_ready | input | 1 | FIFO occupancy is at or above the trigger level |
| push | input | 1 | One-cycle strobe: a character entered the FIFO |
| pop | input | 1 | One-cycle strobe: a character was read from the FIFO |
| age_irq_en | input | 1 | Lets the timeout status reach the interrupt |
| age_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| age_status | output | 1 | Sticky timeout status |
| age_irq | output | 1 | Timeout contribution to the interrupt |

## Verification
The only visible evidence of the internal counter and run state is the edge on which `age_status` rises. An off-by-one count limit moves that rise by one cycle, and the bench catches it by checking the exact edge after every restart offset. A run state that is left set after the window closes shows up as a spurious rise within TIMEOUT cycles of the window reopening. A run state that is not cleared by expiry shows up within TIMEOUT cycles of a clear.

// File: rtl/rxage_pkg.sv
package rxage_pkg;

  // Run state of the idle-character timer.
  typedef enum logic {
    AGE_IDLE = 1'b0,
    AGE_RUN  = 1'b1
  } age_state_e;

  // Bits needed to hold the values 0 .. limit-1 (at least one bit).
  function automatic int unsigned count_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((longint'(1) << w) < longint'(limit)) begin
      w++;
    end
    return w;
  endfunction

endpackage

// File: rtl/rxage_window.sv
// Decides when the timer may count and when it must restart.
module rxage_window (
  input  logic fifo_empty,
  input  logic rx_ready,
  input  logic push,
  input  logic pop,
  output logic restart,
  output logic window_open
);

  always_comb begin
    restart     = push | pop;
    window_open = ~fifo_empty & ~rx_ready;
  end

endmodule

// File: rtl/rxage_counter.sv
// Timeout counter with restart, stop and a single-cycle expiry pulse.
module rxage_counter
  import rxage_pkg::*;
#(
  parameter int unsigned TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic window_open,
  output logic expire
);

  localparam int unsigned CNT_W = count_width(TIMEOUT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  age_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  // Next state: a restart wins over everything, a closed window stops the
  // count, and the final count stops it with an expiry pulse.
  always_comb begin
    at_last = (cnt_q == LAST);
    state_d = state_q;
    cnt_d   = cnt_q;
    expire  = 1'b0;
    if (restart) begin
      state_d = AGE_RUN;
      cnt_d   = '0;
    end else if (!window_open) begin
      state_d = AGE_IDLE;
      cnt_d   = '0;
    end else if (state_q == AGE_RUN) begin
      if (at_last) begin
        expire  = 1'b1;
        state_d = AGE_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Clock enable: the registers hold while idle with the window open.
  always_comb begin
    cnt_en = restart | ~window_open | (state_q == AGE_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AGE_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/rxage_flag.sv
// Sticky status bit (set wins over clear) and its gated interrupt.
module rxage_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic irq_en,
  output logic status,
  output logic irq
);

  logic status_q, status_d;
  logic flag_en;

  always_comb begin
    flag_en  = expire | clr;
    status_d = expire | (status_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (flag_en) begin
      status_q <= status_d;
    end
  end

  always_comb begin
    status = status_q;
    irq    = status_q & irq_en;
  end

endmodule

// File: rtl/rx_fifo_ageing.sv
// Idle-character timeout for a UART receive FIFO.
module rx_fifo_ageing #(
  parameter int unsigned CYCLES_PER_BIT = 868,
  parameter int unsigned CHAR_BITS      = 10,
  parameter int unsigned AGE_CHARS      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_empty,
  input  logic rx_ready,
  input  logic push,
  input  logic pop,
  input  logic age_irq_en,
  input  logic age_clr,
  output logic age_status,
  output logic age_irq
);

  localparam int unsigned TIMEOUT_CYCLES = CYCLES_PER_BIT * CHAR_BITS * AGE_CHARS;

  logic restart;
  logic window_open;
  logic expire;

  rxage_window u_window (
    .fifo_empty  (fifo_empty),
    .rx_ready    (rx_ready),
    .push        (push),
    .pop         (pop),
    .restart     (restart),
    .window_open (window_open)
  );

  rxage_counter #(
    .TIMEOUT (TIMEOUT_CYCLES)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .window_open (window_open),
    .expire      (expire)
  );

  rxage_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr    (age_clr),
    .irq_en (age_irq_en),
    .status (age_status),
    .irq    (age_irq)
  );

endmodule

// File: rtl/rx_fifo_ageing_chk.sv
// Property checker for rx_fifo_ageing, attached by bind below.
module rx_fifo_ageing_chk
  import rxage_pkg::*;
#(
  parameter int unsigned TIMEOUT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic rx_ready,
  input logic push,
  input logic pop,
  input logic age_clr,
  input logic age_status
);

  localparam int unsigned SAT   = TIMEOUT + 1;
  localparam int unsigned CHK_W = count_width(TIMEOUT + 2);

  // Independent window counter: edges with the window open since the last restart.
  logic [CHK_W-1:0] chk_cnt;
  logic             chk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt   <= '0;
      chk_valid <= 1'b0;
    end else if (push || pop) begin
      chk_cnt   <= '0;
      chk_valid <= 1'b1;
    end else if (fifo_empty || rx_ready) begin
      chk_cnt   <= '0;
      chk_valid <= 1'b0;
    end else if (chk_valid && (chk_cnt != CHK_W'(SAT))) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  // R2: a rise comes exactly TIMEOUT open-window edges after a restart
  a_r2_exact_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(age_status) |-> (chk_valid && (chk_cnt == CHK_W'(TIMEOUT))));

  // R3 / R4: an edge with a restart never produces an expiry
  a_r3_r4_restart_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |=> !$rose(age_status));

  // R5: empty FIFO blocks expiry
  a_r5_empty_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !$rose(age_status));

  // R6: receive-ready blocks expiry
  a_r6_ready_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !$rose(age_status));

  // R7: sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (age_status && !age_clr) |=> age_status);

  // R7: clear takes effect when no expiry is possible
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (age_clr && fifo_empty) |=> !age_status);

endmodule

bind rx_fifo_ageing rx_fifo_ageing_chk #(
  .TIMEOUT (TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_empty (fifo_empty),
  .rx_ready   (rx_ready),
  .push       (push),
  .pop        (pop),
  .age_clr    (age_clr),
  .age_status (age_status)
);

// File: tb/sim_rx_fifo_ageing.sv
`timescale 1ns/100ps
module sim_rx_fifo_ageing;

  localparam int T = 8;  // 1 cycle/bit * 1 bit/char * 8 chars

  logic clk;
  logic rst_n;
  logic fifo_empty, rx_ready, push, pop, age_irq_en, age_clr;
  logic age_status, age_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  rx_fifo_ageing #(
    .CYCLES_PER_BIT (1),
    .CHAR_BITS      (1),
    .AGE_CHARS      (8)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .rx_ready   (rx_ready),
    .push       (push),
    .pop        (pop),
    .age_irq_en (age_irq_en),
    .age_clr    (age_clr),
    .age_status (age_status),
    .age_irq    (age_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic p, input logic po, input logic e,
                      input logic r, input logic c);
    push = p; pop = po; fifo_empty = e; rx_ready = r; age_clr = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    step(0, 0, 1, 0, 1);
    check(age_status, 1'b0, "R7 clear");
  endtask

  initial begin
    rst_n = 1'b0;
    push = 0; pop = 0; fifo_empty = 1; rx_ready = 0; age_clr = 0; age_irq_en = 1;
    repeat (3) @(negedge clk);
    check(age_status, 1'b0, "R1 reset status");
    check(age_irq, 1'b0, "R1 reset irq");
    rst_n = 1'b1;

    // R1: window open after reset but no restart -> never fires
    for (int j = 0; j < 3 * T; j++) begin
      step(0, 0, 0, 0, 0);
      check(age_status, 1'b0, "R1 idle after reset");
    end

    // R2 / R8: exact expiry edge, with and without the interrupt enable
    for (int en = 0; en < 2; en++) begin
      age_irq_en = en[0];
      clear_all();
      step(1, 0, 1, 0, 0);
      for (int j = 1; j <= T + 3; j++) begin
        step(0, 0, 0, 0, 0);
        check(age_status, (j >= T), "R2 expiry edge");
        check(age_irq, (j >= T) && en[0], "R8 irq gating");
      end
    end
    age_irq_en = 1'b1;

    // R3 (push) and R4 (pop): restart at every offset inside a count
    for (int kind = 0; kind < 2; kind++) begin
      for (int p = 0; p < T; p++) begin
        clear_all();
        step(1, 0, 1, 0, 0);
        for (int j = 0; j < p; j++) begin
          step(0, 0, 0, 0, 0);
          check(age_status, 1'b0, kind == 0 ? "R3 before push" : "R4 before pop");
        end
        step(kind == 0, kind == 1, 0, 0, 0);
        for (int j = 1; j <= T; j++) begin
          step(0, 0, 0, 0, 0);
          check(age_status, (j == T), kind == 0 ? "R3 restart by push" : "R4 restart by pop");
        end
      end
    end

    // R5 (empty) and R6 (ready): a closed window stops the count for good
    for (int kind = 0; kind < 2; kind++) begin
      for (int p = 0; p < T; p++) begin
        clear_all();
        step(1, 0, 1, 0, 0);
        for (int j = 0; j < p; j++) step(0, 0, 0, 0, 0);
        step(0, 0, kind == 0, kind == 1, 0);
        for (int j = 0; j < T + 4; j++) begin
          step(0, 0, 0, 0, 0);
          check(age_status, 1'b0, kind == 0 ? "R5 empty stops" : "R6 ready stops");
        end
      end
    end

    // R7: sticky through flag changes, then set wins over simultaneous clear
    clear_all();
    step(1, 0, 1, 0, 0);
    for (int j = 0; j < T; j++) step(0, 0, 0, 0, 0);
    check(age_status, 1'b1, "R7 set");
    step(0, 0, 1, 0, 0);
    check(age_status, 1'b1, "R7 sticky empty");
    step(0, 0, 0, 1, 0);
    check(age_status, 1'b1, "R7 sticky ready");
    clear_all();
    step(1, 0, 1, 0, 0);
    for (int j = 0; j < T - 1; j++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    check(age_status, 1'b1, "R7 set wins over clear");

    // R9: after expiry, the timer stays stopped until a restart
    step(0, 0, 0, 0, 1);
    check(age_status, 1'b0, "R9 clear after expiry");
    for (int j = 0; j < 3 * T; j++) begin
      step(0, 0, 0, 0, 0);
      check(age_status, 1'b0, "R9 idle after expiry");
    end
    step(0, 1, 0, 0, 0);
    for (int j = 1; j <= T; j++) begin
      step(0, 0, 0, 0, 0);
      check(age_status, (j == T), "R9 rearm by pop");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule